// File: doc/BRIEF.md
# Colour Channel Multiplexer Sequencer

This block decides which of three per-colour sample paths (red, green, blue) feeds a single shared converter on each conversion slot of a pixel. It runs on a fast system clock and receives two single-cycle strobes that were synchronised upstream. The pixel strobe marks the rising edge of the data-sampling clock and restarts the sequence. The ADC strobe marks a rising converter-clock edge and moves the sequence forward.

Three configuration inputs pick the operating mode. The tri-colour bit forces a three-channel sweep. When that bit is clear, the three enable bits choose either a fixed single channel or an ordered pair. The direction bit decides whether the sweep runs from red towards blue or the other way. The outputs are registered: a 2-bit channel index, a valid flag and a marker that flags the first slot of each pixel.

Top module: `rgb_mux_seq`

## Requirements
- R1: After reset, chan_o = 0, valid_o = 0 and first_o = 0. ADC strobes that arrive before the first pixel strobe leave all outputs unchanged.
- R2: The outputs change only in the cycle after an accepted ADC strobe. A pixel strobe on its own does not change them. A pixel strobe in the same cycle as an ADC strobe wins, and that ADC strobe is discarded.
- R3: The first ADC strobe after a pixel strobe selects the first channel of the sequence and raises first_o. The next accepted ADC strobe clears first_o, so first_o lasts exactly one ADC slot.
- R4: With cfg_tri_i = 1, the sequence is R, G, B when cfg_fwd_i = 1 and B, G, R when cfg_fwd_i = 0. The enable bits cfg_en_i are ignored in this mode.
- R5: With cfg_tri_i = 0 and exactly two bits of cfg_en_i set, the block runs a pair. Bit 0 enables red, bit 1 enables green and bit 2 enables blue. With cfg_fwd_i = 1 the lower-numbered channel comes first (RG, RB, GB). With cfg_fwd_i = 0 each pair is reversed (GR, BR, BG).
- R6: With cfg_tri_i = 0 and exactly one bit of cfg_en_i set, every accepted ADC strobe selects that same channel.
- R7: After the last channel of a sequence, further ADC strobes keep selecting the last channel until the next pixel strobe. The sequence never wraps.
- R8: With cfg_tri_i = 0 and zero or three enable bits set, the configuration is illegal. Every accepted ADC strobe then gives valid_o = 0, chan_o = 0 and first_o = 0.
- R9: A pixel strobe in the middle of a sequence restarts it, so the following ADC strobe selects the first channel again, with first_o = 1.
- R10: chan_o encodes red as 0, green as 1 and blue as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_stb_i | input | 1 | Single-cycle pixel-start strobe |
| adc_stb_i | input | 1 | Single-cycle converter-clock rising-edge strobe |
| cfg_tri_i | input | 1 | Forces the three-channel sweep |
| cfg_fwd_i | input | 1 | Direction: 1 = red towards blue |
| cfg_en_i | input | 3 | Channel enables: bit 0 red, bit 1 green, bit 2 blue |
| chan_o | output | 2 | Selected channel index |
| valid_o | output | 1 | Selection belongs to a legal mode |
| first_o | output | 1 | First slot of the current pixel |

## Verification
The assertions assume that the strobes are single-cycle pulses. They also assume that the configuration is quasi-static: it changes only between ADC strobes and is followed by a pixel strobe before it is relied on. The one-channel property samples the enables in the strobe cycle, so a change in that same cycle would break it.

The stimulus obeys these rules:
- Configuration is written only at the start of a scenario, and a pixel strobe always follows it.
- Each strobe is a single-cycle pulse driven on the falling clock edge.
- The only deliberate overlap of the two strobes is the scenario that checks the priority rule.

// File: rtl/rgb_seq_pkg.sv
package rgb_seq_pkg;
    localparam int NUM_CH = 3;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int STEP_W = $clog2(NUM_CH + 1);

    typedef enum logic [CH_W-1:0] {
        CH_R = 2'd0,
        CH_G = 2'd1,
        CH_B = 2'd2
    } chan_e;

    typedef struct packed {
        logic              pending;
        logic              running;
        logic [STEP_W-1:0] step;
    } trk_s;

    typedef struct packed {
        chan_e chan;
        logic  valid;
        logic  first;
    } out_s;
endpackage

// File: rtl/rgb_seq_cfg_dec.sv
module rgb_seq_cfg_dec
    import rgb_seq_pkg::*;
(
    input  logic              cfg_tri_i,
    input  logic              cfg_fwd_i,
    input  logic [NUM_CH-1:0] cfg_en_i,
    output logic              legal_o,
    output logic [STEP_W-1:0] len_o,
    output chan_e             slots_o [NUM_CH]
);
    logic [NUM_CH-1:0] en_eff;
    logic [STEP_W-1:0] cnt;
    chan_e             asc [NUM_CH];

    // Gather the enabled channels in ascending order.
    always_comb begin
        en_eff = cfg_tri_i ? {NUM_CH{1'b1}} : cfg_en_i;
        cnt    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            asc[i] = CH_R;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (en_eff[i]) begin
                asc[int'(cnt)] = chan_e'(i);
                cnt            = cnt + 1'b1;
            end
        end
        legal_o = cfg_tri_i || (cnt == STEP_W'(1)) || (cnt == STEP_W'(2));
        len_o   = legal_o ? cnt : '0;
    end

    // Apply the direction bit: reversed order reads the list from its end.
    always_comb begin
        for (int j = 0; j < NUM_CH; j++) begin
            int r;
            r = int'(len_o) - 1 - j;
            if (!cfg_fwd_i && r >= 0) begin
                slots_o[j] = asc[r];
            end else begin
                slots_o[j] = asc[j];
            end
        end
    end
endmodule

// File: rtl/rgb_seq_step.sv
module rgb_seq_step
    import rgb_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pix_stb_i,
    input  logic              adc_stb_i,
    input  logic [STEP_W-1:0] len_i,
    output logic              fire_o,
    output logic              is_first_o,
    output logic [STEP_W-1:0] idx_o
);
    trk_s trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        fire_o     = adc_stb_i && !pix_stb_i && (trk_q.pending || trk_q.running);
        is_first_o = trk_q.pending;

        // Clamp the slot index to the last channel, so the sequence holds there.
        if (trk_q.pending || len_i == '0) begin
            idx_o = '0;
        end else if (trk_q.step >= len_i) begin
            idx_o = len_i - 1'b1;
        end else begin
            idx_o = trk_q.step;
        end

        if (pix_stb_i) begin
            trk_d.pending = 1'b1;
            trk_d.running = 1'b0;
            trk_d.step    = '0;
        end else if (fire_o) begin
            trk_d.pending = 1'b0;
            trk_d.running = 1'b1;
            if (trk_q.pending) begin
                trk_d.step = STEP_W'(1);
            end else if (trk_q.step != STEP_W'(NUM_CH)) begin
                trk_d.step = trk_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end
endmodule

// File: rtl/rgb_seq_out.sv
module rgb_seq_out
    import rgb_seq_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  fire_i,
    input  logic  legal_i,
    input  logic  is_first_i,
    input  chan_e chan_i,
    output chan_e chan_o,
    output logic  valid_o,
    output logic  first_o
);
    out_s out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (fire_i) begin
            out_d.chan  = legal_i ? chan_i : CH_R;
            out_d.valid = legal_i;
            out_d.first = is_first_i && legal_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{chan: CH_R, valid: 1'b0, first: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign chan_o  = out_q.chan;
    assign valid_o = out_q.valid;
    assign first_o = out_q.first;
endmodule

// File: rtl/rgb_mux_seq.sv
module rgb_mux_seq
    import rgb_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pix_stb_i,
    input  logic              adc_stb_i,
    input  logic              cfg_tri_i,
    input  logic              cfg_fwd_i,
    input  logic [NUM_CH-1:0] cfg_en_i,
    output logic [CH_W-1:0]   chan_o,
    output logic              valid_o,
    output logic              first_o
);
    logic              legal;
    logic [STEP_W-1:0] len;
    chan_e             slots [NUM_CH];
    logic              fire;
    logic              is_first;
    logic [STEP_W-1:0] idx;
    chan_e             chan_sel;
    chan_e             chan_q;

    rgb_seq_cfg_dec dec_i (
        .cfg_tri_i (cfg_tri_i),
        .cfg_fwd_i (cfg_fwd_i),
        .cfg_en_i  (cfg_en_i),
        .legal_o   (legal),
        .len_o     (len),
        .slots_o   (slots)
    );

    rgb_seq_step step_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pix_stb_i  (pix_stb_i),
        .adc_stb_i  (adc_stb_i),
        .len_i      (len),
        .fire_o     (fire),
        .is_first_o (is_first),
        .idx_o      (idx)
    );

    always_comb begin
        chan_sel = CH_R;
        for (int k = 0; k < NUM_CH; k++) begin
            if (idx == STEP_W'(k)) begin
                chan_sel = slots[k];
            end
        end
    end

    rgb_seq_out out_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fire_i     (fire),
        .legal_i    (legal),
        .is_first_i (is_first),
        .chan_i     (chan_sel),
        .chan_o     (chan_q),
        .valid_o    (valid_o),
        .first_o    (first_o)
    );

    assign chan_o = chan_q;
endmodule

// File: rtl/rgb_seq_chk.sv
module rgb_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pix_stb_i,
    input logic       adc_stb_i,
    input logic       cfg_tri_i,
    input logic [2:0] cfg_en_i,
    input logic [1:0] chan_o,
    input logic       valid_o,
    input logic       first_o
);
    logic [1:0] single_idx;
    assign single_idx = cfg_en_i[0] ? 2'd0 : (cfg_en_i[1] ? 2'd1 : 2'd2);

    // R2
    no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adc_stb_i |=> ($stable(chan_o) && $stable(valid_o) && $stable(first_o)));

    // R2
    pix_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_stb_i |=> ($stable(chan_o) && $stable(valid_o) && $stable(first_o)));

    // R3
    first_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (first_o && adc_stb_i && !pix_stb_i) |=> !first_o);

    // R8
    illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (chan_o == 2'd0 && !first_o));

    // R6
    single_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adc_stb_i && !pix_stb_i && !cfg_tri_i && $countones(cfg_en_i) == 1)
        |=> (!valid_o || chan_o == $past(single_idx)));

    // R10
    chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chan_o != 2'd3);
endmodule

bind rgb_mux_seq rgb_seq_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_stb_i (pix_stb_i),
    .adc_stb_i (adc_stb_i),
    .cfg_tri_i (cfg_tri_i),
    .cfg_en_i  (cfg_en_i),
    .chan_o    (chan_o),
    .valid_o   (valid_o),
    .first_o   (first_o)
);

// File: tb/rgb_mux_seq_tb_top.sv
module rgb_mux_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix = 1'b0;
    logic       adc = 1'b0;
    logic       tri_c = 1'b0;
    logic       fwd = 1'b1;
    logic [2:0] en = 3'b001;
    logic [1:0] chan;
    logic       valid;
    logic       first;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    rgb_mux_seq dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pix_stb_i (pix),
        .adc_stb_i (adc),
        .cfg_tri_i (tri_c),
        .cfg_fwd_i (fwd),
        .cfg_en_i  (en),
        .chan_o    (chan),
        .valid_o   (valid),
        .first_o   (first)
    );

    // Expected {valid, chan} for slot k of a pixel, taken from the requirements.
    function automatic logic [2:0] model(input logic t, input logic f,
                                         input logic [2:0] s, input int k);
        int lst [3];
        int n = 0;
        int kk = k;
        logic [2:0] e = t ? 3'b111 : s;
        for (int i = 0; i < 3; i++) begin
            lst[i] = 0;
        end
        for (int i = 0; i < 3; i++) begin
            if (e[i]) begin
                lst[n] = i;
                n++;
            end
        end
        if (!(t || n == 1 || n == 2)) return 3'b000;
        if (kk > n - 1) kk = n - 1;
        return {1'b1, 2'(lst[f ? kk : n - 1 - kk])};
    endfunction

    task automatic check(input string req, input logic [1:0] ec,
                         input logic ev, input logic ef);
        n_cmp++;
        if (chan !== ec || valid !== ev || first !== ef) begin
            n_bad++;
            $display("FAIL %s: got chan=%0d valid=%0b first=%0b, expected chan=%0d valid=%0b first=%0b",
                     req, chan, valid, first, ec, ev, ef);
        end
    endtask

    task automatic pix_pulse();
        @(negedge clk); pix = 1'b1;
        @(negedge clk); pix = 1'b0;
    endtask

    task automatic adc_pulse();
        @(negedge clk); adc = 1'b1;
        @(negedge clk); adc = 1'b0;
    endtask

    task automatic run_pixel(input string req, input int nslots);
        logic [2:0] m;
        pix_pulse();
        for (int k = 0; k < nslots; k++) begin
            adc_pulse();
            m = model(tri_c, fwd, en, k);
            check(req, m[1:0], m[2], (k == 0) && m[2]);
        end
    endtask

    task automatic t_reset();
        check("R1 reset", 2'd0, 1'b0, 1'b0);
        adc_pulse();
        adc_pulse();
        check("R1 adc before pixel", 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_tri();
        tri_c = 1'b1; en = 3'b010;
        fwd = 1'b1; run_pixel("R4 R7 tri forward", 5);
        fwd = 1'b0; run_pixel("R4 R7 tri reverse", 5);
        en = 3'b000; fwd = 1'b1; run_pixel("R4 tri ignores enables", 3);
    endtask

    task automatic t_pairs();
        tri_c = 1'b0;
        for (int f = 0; f < 2; f++) begin
            fwd = f[0];
            en = 3'b011; run_pixel("R5 R7 pair RG", 3);
            en = 3'b101; run_pixel("R5 R7 pair RB", 3);
            en = 3'b110; run_pixel("R5 R7 pair GB", 3);
        end
    endtask

    task automatic t_single();
        tri_c = 1'b0;
        for (int f = 0; f < 2; f++) begin
            fwd = f[0];
            en = 3'b001; run_pixel("R6 single red", 3);
            en = 3'b010; run_pixel("R6 single green", 3);
            en = 3'b100; run_pixel("R6 single blue", 3);
        end
    endtask

    task automatic t_illegal();
        tri_c = 1'b0; fwd = 1'b1;
        en = 3'b000; run_pixel("R8 none enabled", 2);
        en = 3'b111; run_pixel("R8 all enabled without tri", 2);
    endtask

    task automatic t_restart();
        tri_c = 1'b1; fwd = 1'b1; en = 3'b000;
        pix_pulse();
        adc_pulse(); check("R9 slot0", 2'd0, 1'b1, 1'b1);
        adc_pulse(); check("R9 slot1", 2'd1, 1'b1, 1'b0);
        pix_pulse();
        check("R2 pixel strobe alone holds", 2'd1, 1'b1, 1'b0);
        adc_pulse(); check("R9 restart selects first", 2'd0, 1'b1, 1'b1);
        adc_pulse(); check("R3 first cleared", 2'd1, 1'b1, 1'b0);
    endtask

    task automatic t_collide();
        tri_c = 1'b1; fwd = 1'b0; en = 3'b000;
        pix_pulse();
        adc_pulse(); check("R3 reverse first", 2'd2, 1'b1, 1'b1);
        adc_pulse(); check("R4 reverse second", 2'd1, 1'b1, 1'b0);
        @(negedge clk); pix = 1'b1; adc = 1'b1;
        @(negedge clk); pix = 1'b0; adc = 1'b0;
        check("R2 collision discards adc", 2'd1, 1'b1, 1'b0);
        adc_pulse(); check("R2 after collision first", 2'd2, 1'b1, 1'b1);
        adc_pulse(); check("R10 green code", 2'd1, 1'b1, 1'b0);
        adc_pulse(); check("R10 red code", 2'd0, 1'b1, 1'b0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tri();
        t_pairs();
        t_single();
        t_illegal();
        t_restart();
        t_collide();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule